// File: doc/BRIEF.md
# USB OUT Endpoint Receive Buffer Controller

This block is the receive half of one USB device OUT endpoint. The serial engine delivers each data packet as a start strobe carrying the PID toggle, a run of byte strobes, and an end strobe carrying CRC and bit-stuffing error flags. The block stores the payload in a byte FIFO and decides the handshake for the packet. It keeps the expected DATA0/DATA1 toggle and reports events in an 8-bit control/status byte. Firmware reads stored payload through a byte read port and releases packets through the status byte.

A maximum-packet-size byte sets the buffering. If it is at most half the FIFO, the FIFO is split into two packet slots. If it is larger, the whole FIFO is one slot. In isochronous mode no handshake is given, and corrupted data is kept but flagged. In bulk/interrupt mode the toggle is enforced and corrupted packets are ignored without a reply. An optional auto-release frees a packet as soon as a maximum-size run of bytes has been read from it.

Top module: `usb_out_ep_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, the max-packet byte reads 0, no handshake is issued and no packet is buffered.
- R2: Status bit positions: 0 ready, 1 overrun, 2 CPU stall, 3 isochronous/toggle-init, 4 forced stall, 5 data error, 6 flush, 7 auto-release. The flags in bits 0, 1, 4 and 5 are cleared only by writing 0 to them. Writing 1 to them leaves them unchanged. Bit 6 always reads 0. Bits 2, 3 and 7 hold the written value.
- R3: A packet longer than the limit is answered STALL (hs_code 2) and discarded, and it sets the forced-stall flag. The limit is the max-packet size capped at the slot capacity. While the flag is set, every packet is answered STALL.
- R4: While the CPU stall bit is set, every packet is answered STALL and discarded.
- R5: In non-isochronous mode, an error-free packet whose PID matches the expected toggle is stored, answered ACK (hs_code 1), and flips the toggle. The handshake pulse and the ready flag appear one cycle after the end strobe.
- R6: In non-isochronous mode, a packet whose PID does not match the toggle is answered ACK and discarded. The toggle is unchanged.
- R7: A write that changes bit 3 from 1 to 0 makes the next expected PID DATA0.
- R8: With max-packet size at most half the FIFO depth, two packets are buffered. Above that, one packet is buffered.
- R9: A packet that ends when no slot is free sets the overrun flag, gets no handshake and is dropped.
- R10: Writing 1 to bit 6 discards the oldest buffered packet. A second buffered packet becomes the head and ready stays 1.
- R11: Writing 0 to bit 0 while ready releases the oldest packet.
- R12: With auto-release set, the head packet is released on the read that completes max-packet-size bytes from it.
- R13: In isochronous mode, packets get no handshake and are stored even when corrupted, and a CRC or stuffing error sets the data-error flag. In non-isochronous mode a corrupted packet gets no handshake and is not stored.
- R14: The read port returns the head packet's bytes in arrival order, and pkt_len gives its byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_start | input | 1 | Start of a data packet |
| rx_data1 | input | 1 | PID of the starting packet is DATA1 (0 = DATA0) |
| rx_valid | input | 1 | Payload byte strobe |
| rx_byte | input | 8 | Payload byte |
| rx_end | input | 1 | End of packet |
| rx_crc_err | input | 1 | CRC error, valid with rx_end |
| rx_stuff_err | input | 1 | Bit-stuffing error, valid with rx_end |
| hs_valid | output | 1 | One-cycle handshake pulse |
| hs_code | output | 2 | 1 = ACK, 2 = STALL |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = status byte, 1 = max-packet byte |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Selected register value |
| fifo_rd | input | 1 | Advance the read pointer of the head packet |
| fifo_rdata | output | 8 | Byte at the head read pointer |
| pkt_len | output | 7 | Byte count of the head packet |

## Verification
A wrong slot index or packet count is visible at the read port. The head bytes or pkt_len mismatch on the first read after a flush or release, and a third packet is either wrongly accepted or wrongly rejected, which the handshake shows at once. A stale toggle shows up one packet later as a discarded packet that was still ACKed, with ready staying 0. A flag that sets or clears at the wrong time shows in the status byte in the cycle after the causing write or end strobe.

// File: rtl/usb_out_ep_pkg.sv
package usb_out_ep_pkg;
    typedef enum logic [1:0] {
        HS_NONE  = 2'd0,
        HS_ACK   = 2'd1,
        HS_STALL = 2'd2
    } hs_code_e;

    // status byte bit positions (firmware decodes these)
    localparam int unsigned B_RDY    = 0;
    localparam int unsigned B_OVR    = 1;
    localparam int unsigned B_SSTALL = 2;
    localparam int unsigned B_ISO    = 3;
    localparam int unsigned B_FSTALL = 4;
    localparam int unsigned B_DERR   = 5;
    localparam int unsigned B_FLUSH  = 6;
    localparam int unsigned B_AUTO   = 7;
endpackage

// File: rtl/out_ep_fifo.sv
module out_ep_fifo #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dual,
    input  logic          pkt_start,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          commit,
    input  logic          pop,
    input  logic          rd_en,
    output logic          free,
    output logic [1:0]    pkt_cnt,
    output logic [LW-1:0] head_len,
    output logic [LW-1:0] rd_cnt,
    output logic [7:0]    rd_data
);
    localparam int HALF = DEPTH / 2;

    typedef struct packed {
        logic                hd;
        logic [1:0]          cnt;
        logic [LW-1:0]       wlen;
        logic [1:0][LW-1:0]  len;
        logic [LW-1:0]       rcnt;
    } fifo_st_t;

    fifo_st_t fifo_d, fifo_q;
    logic [7:0] mem [DEPTH];

    logic [LW-1:0] cap;
    logic          wslot, rslot, wr_ok, commit_ok, pop_ok;
    logic [AW-1:0] waddr, raddr;

    always_comb begin
        cap       = dual ? LW'(HALF) : LW'(DEPTH);
        free      = dual ? (fifo_q.cnt < 2'd2) : (fifo_q.cnt == 2'd0);
        wslot     = dual & (fifo_q.hd ^ fifo_q.cnt[0]);
        rslot     = dual & fifo_q.hd;
        wr_ok     = wr_en && free && (fifo_q.wlen < cap);
        commit_ok = commit && free;
        pop_ok    = pop && (fifo_q.cnt != 2'd0);
        waddr     = (wslot ? AW'(HALF) : '0) + AW'(fifo_q.wlen);
        raddr     = (rslot ? AW'(HALF) : '0) + AW'(fifo_q.rcnt);

        fifo_d = fifo_q;
        if (pkt_start)
            fifo_d.wlen = '0;
        else if (wr_ok)
            fifo_d.wlen = fifo_q.wlen + LW'(1);
        if (commit_ok)
            fifo_d.len[wslot] = fifo_q.wlen;
        if (rd_en && (fifo_q.cnt != 2'd0) && (fifo_q.rcnt < cap))
            fifo_d.rcnt = fifo_q.rcnt + LW'(1);
        if (pop_ok) begin
            fifo_d.hd   = dual & ~fifo_q.hd;
            fifo_d.rcnt = '0;
        end
        fifo_d.cnt = fifo_q.cnt + {1'b0, commit_ok} - {1'b0, pop_ok};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fifo_q <= '0;
        else        fifo_q <= fifo_d;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[waddr] <= wr_data;
    end

    assign pkt_cnt  = fifo_q.cnt;
    assign head_len = fifo_q.len[rslot];
    assign rd_cnt   = fifo_q.rcnt;
    assign rd_data  = mem[raddr];

    // releasing the only packet empties the buffer
    assert_pop_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !commit && fifo_q.cnt == 2'd1) |=> (fifo_q.cnt == 2'd0));

    // a full buffer never accepts another packet
    assert_full_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!free && commit && !pop) |=> $stable(fifo_q.cnt));
endmodule

// File: rtl/out_ep_rx.sv
module out_ep_rx
    import usb_out_ep_pkg::*;
#(
    parameter int LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_start,
    input  logic             rx_data1,
    input  logic             rx_valid,
    input  logic             rx_end,
    input  logic             rx_crc_err,
    input  logic             rx_stuff_err,
    input  logic             iso,
    input  logic             toggle,
    input  logic             stall_active,
    input  logic [LEN_W-1:0] limit,
    input  logic             free,
    output logic             fifo_wr,
    output logic             commit,
    output logic             set_forced,
    output logic             set_overrun,
    output logic             set_derr,
    output logic             flip_toggle,
    output logic             hs_valid,
    output logic [1:0]       hs_code
);
    typedef struct packed {
        logic             active;
        logic             pid1;
        logic [LEN_W-1:0] len;
        logic             hs_valid;
        hs_code_e         hs_code;
    } rx_st_t;

    rx_st_t rx_d, rx_q;
    logic   bad;

    always_comb begin
        rx_d          = rx_q;
        rx_d.hs_valid = 1'b0;
        rx_d.hs_code  = HS_NONE;
        commit        = 1'b0;
        set_forced    = 1'b0;
        set_overrun   = 1'b0;
        set_derr      = 1'b0;
        flip_toggle   = 1'b0;
        bad           = rx_crc_err | rx_stuff_err;
        fifo_wr       = rx_valid && rx_q.active;

        if (rx_start) begin
            rx_d.active = 1'b1;
            rx_d.pid1   = rx_data1;
            rx_d.len    = '0;
        end else if (fifo_wr && (rx_q.len != '1)) begin
            rx_d.len = rx_q.len + LEN_W'(1);
        end

        if (rx_end && rx_q.active) begin
            rx_d.active = 1'b0;
            if (stall_active) begin
                rx_d.hs_valid = 1'b1;
                rx_d.hs_code  = HS_STALL;
            end else if (rx_q.len > limit) begin
                rx_d.hs_valid = 1'b1;
                rx_d.hs_code  = HS_STALL;
                set_forced    = 1'b1;
            end else if (!free) begin
                set_overrun = 1'b1;
            end else if (iso) begin
                commit   = 1'b1;
                set_derr = bad;
            end else if (!bad) begin
                rx_d.hs_valid = 1'b1;
                rx_d.hs_code  = HS_ACK;
                if (rx_q.pid1 == toggle) begin
                    commit      = 1'b1;
                    flip_toggle = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign hs_valid = rx_q.hs_valid;
    assign hs_code  = rx_q.hs_code;

    assert_stall_answer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_end && rx_q.active && stall_active) |=> (hs_valid && hs_code == HS_STALL));

    assert_overrun_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_end && rx_q.active && !stall_active && rx_q.len <= limit && !free) |=> !hs_valid);
endmodule

// File: rtl/out_ep_csr.sv
module out_ep_csr
    import usb_out_ep_pkg::*;
#(
    parameter int MAXP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [7:0]        reg_wdata,
    input  logic              pkt_ready,
    input  logic              set_overrun,
    input  logic              set_forced,
    input  logic              set_derr,
    input  logic              flip_toggle,
    output logic [7:0]        reg_rdata,
    output logic              iso,
    output logic              toggle,
    output logic              stall_active,
    output logic              auto_clr,
    output logic [MAXP_W-1:0] maxp,
    output logic              cpu_pop
);
    typedef struct packed {
        logic              ovr;
        logic              sstall;
        logic              iso;
        logic              forced;
        logic              derr;
        logic              autoc;
        logic              toggle;
        logic [MAXP_W-1:0] maxp;
    } csr_st_t;

    csr_st_t csr_d, csr_q;
    logic    csr_wr, maxp_wr;
    logic [7:0] status;

    always_comb begin
        csr_wr  = reg_wr && !reg_sel;
        maxp_wr = reg_wr && reg_sel;
        csr_d   = csr_q;

        if (csr_wr) begin
            if (!reg_wdata[B_OVR])    csr_d.ovr    = 1'b0;
            if (!reg_wdata[B_FSTALL]) csr_d.forced = 1'b0;
            if (!reg_wdata[B_DERR])   csr_d.derr   = 1'b0;
            csr_d.sstall = reg_wdata[B_SSTALL];
            csr_d.iso    = reg_wdata[B_ISO];
            csr_d.autoc  = reg_wdata[B_AUTO];
            if (csr_q.iso && !reg_wdata[B_ISO]) csr_d.toggle = 1'b0;
        end
        if (maxp_wr) csr_d.maxp = reg_wdata[MAXP_W-1:0];

        if (flip_toggle) csr_d.toggle = ~csr_q.toggle;
        if (set_overrun) csr_d.ovr    = 1'b1;
        if (set_forced)  csr_d.forced = 1'b1;
        if (set_derr)    csr_d.derr   = 1'b1;

        cpu_pop = csr_wr && pkt_ready && (!reg_wdata[B_RDY] || reg_wdata[B_FLUSH]);

        status           = '0;
        status[B_RDY]    = pkt_ready;
        status[B_OVR]    = csr_q.ovr;
        status[B_SSTALL] = csr_q.sstall;
        status[B_ISO]    = csr_q.iso;
        status[B_FSTALL] = csr_q.forced;
        status[B_DERR]   = csr_q.derr;
        status[B_AUTO]   = csr_q.autoc;
        reg_rdata        = reg_sel ? 8'(csr_q.maxp) : status;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) csr_q <= '0;
        else        csr_q <= csr_d;
    end

    assign iso          = csr_q.iso;
    assign toggle       = csr_q.toggle;
    assign stall_active = csr_q.sstall | csr_q.forced;
    assign auto_clr     = csr_q.autoc;
    assign maxp         = csr_q.maxp;

    assert_forced_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(csr_q.forced) |-> $past(reg_wr && !reg_sel && !reg_wdata[B_FSTALL]));

    assert_overrun_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(csr_q.ovr) |-> $past(set_overrun));
endmodule

// File: rtl/usb_out_ep_ctrl.sv
module usb_out_ep_ctrl #(
    parameter int FIFO_DEPTH = 64,
    parameter int MAXP_W     = 8,
    localparam int PL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_start,
    input  logic            rx_data1,
    input  logic            rx_valid,
    input  logic [7:0]      rx_byte,
    input  logic            rx_end,
    input  logic            rx_crc_err,
    input  logic            rx_stuff_err,
    output logic            hs_valid,
    output logic [1:0]      hs_code,
    input  logic            reg_wr,
    input  logic            reg_sel,
    input  logic [7:0]      reg_wdata,
    output logic [7:0]      reg_rdata,
    input  logic            fifo_rd,
    output logic [7:0]      fifo_rdata,
    output logic [PL_W-1:0] pkt_len
);
    localparam int HALF  = FIFO_DEPTH / 2;
    localparam int LEN_W = ((MAXP_W > PL_W) ? MAXP_W : PL_W) + 1;

    logic              iso, toggle, stall_active, auto_clr, cpu_pop;
    logic [MAXP_W-1:0] maxp;
    logic              fifo_wr, commit, set_forced, set_overrun, set_derr, flip_toggle;
    logic              free, dual, pkt_ready, auto_pop, pop;
    logic [1:0]        pkt_cnt;
    logic [PL_W-1:0]   rd_cnt;
    logic [LEN_W-1:0]  maxp_ext, cap_ext, limit;

    always_comb begin
        maxp_ext  = LEN_W'(maxp);
        dual      = (maxp_ext <= LEN_W'(HALF));
        cap_ext   = dual ? LEN_W'(HALF) : LEN_W'(FIFO_DEPTH);
        limit     = (maxp_ext < cap_ext) ? maxp_ext : cap_ext;
        pkt_ready = (pkt_cnt != 2'd0);
        auto_pop  = auto_clr && fifo_rd && pkt_ready
                    && ((LEN_W'(rd_cnt) + LEN_W'(1)) == maxp_ext);
        pop       = cpu_pop | auto_pop;
    end

    out_ep_csr #(.MAXP_W(MAXP_W)) i_csr (
        .clk, .rst_n, .reg_wr, .reg_sel, .reg_wdata, .pkt_ready,
        .set_overrun, .set_forced, .set_derr, .flip_toggle,
        .reg_rdata, .iso, .toggle, .stall_active, .auto_clr, .maxp, .cpu_pop
    );

    out_ep_rx #(.LEN_W(LEN_W)) i_rx (
        .clk, .rst_n, .rx_start, .rx_data1, .rx_valid, .rx_end,
        .rx_crc_err, .rx_stuff_err, .iso, .toggle, .stall_active, .limit, .free,
        .fifo_wr, .commit, .set_forced, .set_overrun, .set_derr, .flip_toggle,
        .hs_valid, .hs_code
    );

    out_ep_fifo #(.DEPTH(FIFO_DEPTH)) i_fifo (
        .clk, .rst_n, .dual, .pkt_start(rx_start), .wr_en(fifo_wr), .wr_data(rx_byte),
        .commit, .pop, .rd_en(fifo_rd), .free, .pkt_cnt, .head_len(pkt_len),
        .rd_cnt, .rd_data(fifo_rdata)
    );

    assert_auto_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_pop && !commit) |=> (pkt_cnt == $past(pkt_cnt) - 2'd1));
endmodule

// File: tb/test_usb_out_ep_ctrl.sv
module test_usb_out_ep_ctrl;
    localparam int CLK_PERIOD      = 10;
    localparam int WATCHDOG_CYCLES = 20000;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       rx_start = 0, rx_data1 = 0, rx_valid = 0, rx_end = 0;
    logic       rx_crc_err = 0, rx_stuff_err = 0;
    logic [7:0] rx_byte = '0;
    logic       hs_valid;
    logic [1:0] hs_code;
    logic       reg_wr = 0, reg_sel = 0;
    logic [7:0] reg_wdata = '0, reg_rdata, fifo_rdata;
    logic       fifo_rd = 0;
    logic [6:0] pkt_len;

    int  checks = 0, errors = 0;
    bit  done = 0;

    usb_out_ep_ctrl i_usb_out_ep_ctrl (
        .clk, .rst_n, .rx_start, .rx_data1, .rx_valid, .rx_byte, .rx_end,
        .rx_crc_err, .rx_stuff_err, .hs_valid, .hs_code, .reg_wr, .reg_sel,
        .reg_wdata, .reg_rdata, .fifo_rd, .fifo_rdata, .pkt_len
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int sbit(input int b);
        return int'((reg_rdata >> b) & 8'h01);
    endfunction

    task automatic wr_reg(input bit sel, input logic [7:0] v);
        reg_sel = sel; reg_wdata = v; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0; reg_sel = 0;
    endtask

    task automatic rd_maxp(output int v);
        reg_sel = 1; #1; v = int'(reg_rdata); reg_sel = 0; #1;
    endtask

    // err: bit0 CRC, bit1 stuffing
    task automatic send_pkt(input bit d1, input int n, input int seed, input int err);
        rx_start = 1; rx_data1 = d1;
        @(negedge clk);
        rx_start = 0;
        for (int i = 0; i < n; i++) begin
            rx_valid = 1; rx_byte = 8'(seed + i);
            @(negedge clk);
        end
        rx_valid = 0; rx_end = 1;
        rx_crc_err = err[0]; rx_stuff_err = err[1];
        @(negedge clk);
        rx_end = 0; rx_crc_err = 0; rx_stuff_err = 0;
    endtask

    task automatic expect_hs(input string req, input int v, input int code);
        chk(req, "hs_valid", int'(hs_valid), v);
        if (v != 0) chk(req, "hs_code", int'(hs_code), code);
    endtask

    task automatic read_bytes(input string req, input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            chk(req, "fifo byte", int'(fifo_rdata), (seed + i) & 255);
            fifo_rd = 1;
            @(negedge clk);
        end
        fifo_rd = 0;
    endtask

    task automatic t_reset;
        int m;
        chk("R1", "status", int'(reg_rdata), 0);
        rd_maxp(m);
        chk("R1", "maxp", m, 0);
        chk("R1", "hs_valid", int'(hs_valid), 0);
    endtask

    task automatic t_basic;
        wr_reg(1, 8'd8);
        send_pkt(0, 4, 'h10, 0);
        expect_hs("R5", 1, 1);
        chk("R5", "ready", sbit(0), 1);
        chk("R14", "pkt_len", int'(pkt_len), 4);
        read_bytes("R14", 4, 'h10);
        wr_reg(0, 8'h32);
        chk("R11", "ready after clear", sbit(0), 0);
    endtask

    task automatic t_mismatch;
        send_pkt(0, 3, 'h18, 0);
        expect_hs("R6", 1, 1);
        chk("R6", "ready after mismatch", sbit(0), 0);
    endtask

    task automatic t_dual_flush;
        send_pkt(1, 2, 'h20, 0);
        expect_hs("R8", 1, 1);
        send_pkt(0, 3, 'h30, 0);
        expect_hs("R8", 1, 1);
        send_pkt(1, 1, 'h40, 0);
        expect_hs("R9", 0, 0);
        chk("R9", "overrun", sbit(1), 1);
        wr_reg(0, 8'h73);
        chk("R10", "ready after flush", sbit(0), 1);
        chk("R10", "pkt_len after flush", int'(pkt_len), 3);
        chk("R2", "flush reads 0", sbit(6), 0);
        read_bytes("R10", 3, 'h30);
        wr_reg(0, 8'h32);
        chk("R11", "ready", sbit(0), 0);
        wr_reg(0, 8'h33);
        chk("R2", "overrun kept on write 1", sbit(1), 1);
        wr_reg(0, 8'h31);
        chk("R2", "overrun cleared on write 0", sbit(1), 0);
    endtask

    task automatic t_modes;
        wr_reg(1, 8'd32);
        send_pkt(1, 1, 'h44, 0);
        send_pkt(0, 1, 'h45, 0);
        expect_hs("R8", 1, 1);
        chk("R8", "no overrun at half", sbit(1), 0);
        wr_reg(0, 8'h32);
        chk("R11", "second packet head", int'(fifo_rdata), 'h45);
        wr_reg(0, 8'h32);
        wr_reg(1, 8'd33);
        send_pkt(1, 5, 'h50, 0);
        expect_hs("R8", 1, 1);
        send_pkt(0, 2, 'h58, 0);
        expect_hs("R8", 0, 0);
        chk("R8", "overrun in single mode", sbit(1), 1);
        chk("R8", "head length", int'(pkt_len), 5);
        wr_reg(0, 8'h32);
        wr_reg(0, 8'h31);
        chk("R11", "empty", sbit(0), 0);
    endtask

    task automatic t_forced;
        wr_reg(1, 8'd8);
        send_pkt(0, 9, 'h60, 0);
        expect_hs("R3", 1, 2);
        chk("R3", "forced flag", sbit(4), 1);
        chk("R3", "not stored", sbit(0), 0);
        send_pkt(0, 2, 'h60, 0);
        expect_hs("R3", 1, 2);
        wr_reg(0, 8'h33);
        chk("R2", "forced kept on write 1", sbit(4), 1);
        wr_reg(0, 8'h23);
        chk("R3", "forced cleared", sbit(4), 0);
        send_pkt(0, 2, 'h68, 0);
        expect_hs("R5", 1, 1);
        wr_reg(0, 8'h32);
    endtask

    task automatic t_sstall;
        wr_reg(0, 8'h37);
        chk("R2", "stall bit", sbit(2), 1);
        send_pkt(1, 2, 'h70, 0);
        expect_hs("R4", 1, 2);
        chk("R4", "not stored", sbit(0), 0);
        wr_reg(0, 8'h33);
        send_pkt(1, 2, 'h72, 0);
        expect_hs("R4", 1, 1);
        wr_reg(0, 8'h32);
    endtask

    task automatic t_toggle_init;
        send_pkt(0, 1, 'h74, 0);
        expect_hs("R7", 1, 1);
        wr_reg(0, 8'h32);
        wr_reg(0, 8'h3B);
        wr_reg(0, 8'h33);
        send_pkt(0, 1, 'h76, 0);
        expect_hs("R7", 1, 1);
        chk("R7", "DATA0 stored after init", sbit(0), 1);
        wr_reg(0, 8'h32);
    endtask

    task automatic t_iso;
        wr_reg(0, 8'h3B);
        send_pkt(0, 3, 'h80, 1);
        expect_hs("R13", 0, 0);
        chk("R13", "data error", sbit(5), 1);
        chk("R13", "stored", sbit(0), 1);
        read_bytes("R13", 3, 'h80);
        wr_reg(0, 8'h1A);
        chk("R13", "data error cleared", sbit(5), 0);
        wr_reg(0, 8'h33);
        send_pkt(0, 2, 'h88, 2);
        expect_hs("R13", 0, 0);
        chk("R13", "bulk error not stored", sbit(0), 0);
    endtask

    task automatic t_auto;
        wr_reg(1, 8'd4);
        wr_reg(0, 8'hB3);
        chk("R2", "auto bit", sbit(7), 1);
        send_pkt(0, 4, 'h90, 0);
        expect_hs("R12", 1, 1);
        read_bytes("R12", 3, 'h90);
        chk("R12", "ready before last", sbit(0), 1);
        read_bytes("R12", 1, 'h93);
        chk("R12", "ready auto-cleared", sbit(0), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_mismatch();
        t_dual_flush();
        t_modes();
        t_forced();
        t_sstall();
        t_toggle_init();
        t_iso();
        t_auto();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule